// File: doc/BRIEF.md
# Multi-Queue Message Mailbox

This block lets two processors pass fixed-size messages through a set of hardware FIFO queues behind a 32-bit register port. Each queue can be reached through several address windows, one per proxy. The producer fills data words in a window's private staging buffer. A write to the window's final data register pushes the staged words, with the written value as the last word, into the queue as one message. The consumer reads the head message word by word through any window of the same queue. Reading the final data register returns the last word and removes the message from the queue.

A second address region holds one read-only status word per queue. It reports the number of pending messages and a sticky flag that is set when a commit reaches a full queue. Each queue drives a level interrupt for as long as it holds a message. Every request is answered exactly one cycle later with a response strobe, read data and an error flag.

Top module: `msg_mailbox`

## Requirements
- R1: Address bit 19 low selects the data region. There the byte address is proxy*0x10000 + queue*0x80 + index*4, and register indices 16 to 31 carry message words 0 to 15. Every window of a queue reads that same queue.
- R2: A write to index 31 pushes one message made of staged words 0 to 14 plus the written value as word 15. Words not written since the last commit read back as zero, and the staging buffer is empty after a commit.
- R3: A commit to a queue that already holds DEPTH (4) messages is discarded and leaves the queue contents unchanged. It sets that queue's overflow flag, which stays set until reset.
- R4: A read of indices 16 to 30 returns the head message's word with no side effect. A read of index 31 returns word 15 and removes the head message.
- R5: A data read from an empty queue returns zero and leaves the count at zero.
- R6: With address bit 19 high, the status word of queue q sits at byte offset q*4. It holds the pending count in bits [23:12] and the overflow flag in bit 0, with all other bits zero. Status reads change nothing.
- R7: irq[q] is high exactly while queue q holds at least one message. It changes only in the cycle after an accepted request.
- R8: These requests are answered with the error flag and zero data and change no state: a byte strobe other than 4'hF, an address that is not word aligned, any address bit outside the decoded fields, a data index below 16, a proxy or queue number that does not exist, and a write to the status region.
- R9: rsp_valid is high in the cycle after each request and low in the cycle after each idle cycle.
- R10: Each proxy/queue window has its own staging buffer. Words staged through one proxy never appear in a message committed through another proxy.
- R11: Messages leave a queue in the order they were committed.
- R12: After reset every queue is empty, every overflow flag is clear, irq is all zero and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_strb | input | 4 | Byte strobes, must be 4'hF |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| irq | output | NUM_QUEUE | Per-queue message-pending level interrupt |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle response timing;
- zero data on errored responses;
- the error flag for bad strobes, misaligned addresses and writes to the status region;
- that irq holds still after idle or rejected cycles;
- that the reserved status bits are zero;
- that the count bits agree with the matching irq line.

Only the bench's scenarios can show the message contents. These include commit and pop order, staging isolation between proxies, zero fill of unwritten words, the overflow drop at four messages and empty-queue reads. The bench checks them against a queue model driven by directed sequences and seeded random traffic.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 20;
    localparam int REG_LSB     = 2;
    localparam int IDX_W       = 5;
    localparam int QUEUE_LSB   = 7;
    localparam int PROXY_LSB   = 16;
    localparam int FIRST_IDX   = 16;
    localparam int LAST_IDX    = 31;
    localparam int WORDS       = LAST_IDX - FIRST_IDX + 1;
    localparam int WORD_W      = $clog2(WORDS);
    localparam int CNT_LSB     = 12;
    localparam int CNT_FIELD_W = 12;
    localparam int OVF_BIT     = 0;
    localparam int FIELD_W     = 8;

    typedef logic [WORDS-1:0][DATA_W-1:0] msg_t;

    typedef struct packed {
        logic               is_state;
        logic               bad;
        logic [FIELD_W-1:0] proxy;
        logic [FIELD_W-1:0] queue;
        logic [WORD_W-1:0]  word;
        logic               last;
    } dec_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NUM_PROXY = 2,
    parameter int NUM_QUEUE = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic [3:0]        strb_i,
    output dec_t              dec_o
);
    localparam int QW = $clog2(NUM_QUEUE);
    localparam int PW = (NUM_PROXY > 1) ? $clog2(NUM_PROXY) : 1;
    localparam int RW = ADDR_W - 1;

    logic [IDX_W-1:0] idx;
    logic [QW-1:0]    qf;
    logic [PW-1:0]    pf;
    logic [RW-1:0]    rebuilt;

    always_comb begin
        dec_o          = '0;
        dec_o.is_state = addr_i[ADDR_W-1];
        idx            = addr_i[REG_LSB +: IDX_W];
        if (dec_o.is_state) begin
            qf      = addr_i[REG_LSB +: QW];
            pf      = '0;
            rebuilt = RW'(qf) << REG_LSB;
        end else begin
            qf      = addr_i[QUEUE_LSB +: QW];
            pf      = addr_i[PROXY_LSB +: PW];
            rebuilt = (RW'(pf) << PROXY_LSB) | (RW'(qf) << QUEUE_LSB)
                    | (RW'(idx) << REG_LSB);
        end
        dec_o.queue = FIELD_W'(qf);
        dec_o.proxy = FIELD_W'(pf);
        dec_o.word  = WORD_W'(idx - IDX_W'(FIRST_IDX));
        dec_o.last  = (idx == IDX_W'(LAST_IDX));
        // reject partial strobes, stray address bits and missing queues
        dec_o.bad   = (strb_i != 4'hF) || (addr_i[RW-1:0] != rebuilt)
                    || (int'(qf) >= NUM_QUEUE);
        if (dec_o.is_state)
            dec_o.bad = dec_o.bad || write_i;
        else
            dec_o.bad = dec_o.bad || (int'(idx) < FIRST_IDX)
                      || (int'(pf) >= NUM_PROXY);
    end
endmodule

// File: rtl/mbx_stage.sv
module mbx_stage
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              clr_i,
    output msg_t              msg_o
);
    typedef struct packed {
        msg_t words;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.words = '0;
        else if (wr_i)
            st_d.words[word_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg_o = st_q.words;
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo
    import mbx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  msg_t                         msg_i,
    input  logic                         pop_i,
    input  logic [WORD_W-1:0]            rd_word_i,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WORDS-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]                        wr;
        logic [PTR_W-1:0]                        rd;
        logic [CNT_W-1:0]                        cnt;
        logic                                    ovf;
    } fifo_t;

    fifo_t f_d, f_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d = f_q;
        if (pop_i && f_q.cnt != '0) begin
            f_d.rd  = bump(f_q.rd);
            f_d.cnt = f_q.cnt - 1'b1;
        end
        if (push_i) begin
            if (int'(f_q.cnt) == DEPTH) begin
                f_d.ovf = 1'b1;
            end else begin
                f_d.mem[f_q.wr] = msg_i;
                f_d.wr          = bump(f_q.wr);
                f_d.cnt         = f_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rd_data_o = (f_q.cnt == '0) ? '0 : f_q.mem[f_q.rd][rd_word_i];
    assign count_o   = f_q.cnt;
    assign ovf_o     = f_q.ovf;
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_PROXY = 2,
    parameter int NUM_QUEUE = 8,
    parameter int DEPTH     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_strb,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_QUEUE-1:0] irq
);
    localparam int QW      = $clog2(NUM_QUEUE);
    localparam int PW      = (NUM_PROXY > 1) ? $clog2(NUM_PROXY) : 1;
    localparam int NUM_WIN = NUM_PROXY * NUM_QUEUE;
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    dec_t              dec;
    logic              acc_ok, data_wr, data_rd;
    logic [QW-1:0]     qsel;
    logic [PW-1:0]     psel;
    logic [WIN_W-1:0]  wsel;
    msg_t              win_msg [NUM_WIN];
    msg_t              push_msg;
    logic [DATA_W-1:0] head_word [NUM_QUEUE];
    logic [CNT_W-1:0]  q_cnt [NUM_QUEUE];
    logic [NUM_QUEUE-1:0] q_ovf;
    logic [DATA_W-1:0] status;
    rsp_t              rsp_d, rsp_q;

    mbx_decode #(.NUM_PROXY(NUM_PROXY), .NUM_QUEUE(NUM_QUEUE)) u_dec (
        .addr_i  (req_addr),
        .write_i (req_write),
        .strb_i  (req_strb),
        .dec_o   (dec)
    );

    assign qsel    = dec.queue[QW-1:0];
    assign psel    = dec.proxy[PW-1:0];
    assign acc_ok  = req_valid && !dec.bad;
    assign data_wr = acc_ok && !dec.is_state && req_write;
    assign data_rd = acc_ok && !dec.is_state && !req_write;

    for (genvar gq = 0; gq < NUM_QUEUE; gq++) begin : g_queue
        logic hit;
        assign hit = (int'(qsel) == gq);

        mbx_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_i    (data_wr && dec.last && hit),
            .msg_i     (push_msg),
            .pop_i     (data_rd && dec.last && hit),
            .rd_word_i (dec.word),
            .rd_data_o (head_word[gq]),
            .count_o   (q_cnt[gq]),
            .ovf_o     (q_ovf[gq])
        );

        assign irq[gq] = (q_cnt[gq] != '0);

        for (genvar gp = 0; gp < NUM_PROXY; gp++) begin : g_win
            logic sel;
            assign sel = hit && (int'(psel) == gp);

            mbx_stage u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_i    (data_wr && !dec.last && sel),
                .word_i  (dec.word),
                .wdata_i (req_wdata),
                .clr_i   (data_wr && dec.last && sel),
                .msg_o   (win_msg[gp*NUM_QUEUE + gq])
            );
        end
    end

    always_comb begin
        // message pushed on commit: staged words with the final one replaced
        wsel                = WIN_W'(int'(psel) * NUM_QUEUE + int'(qsel));
        push_msg            = win_msg[wsel];
        push_msg[WORDS-1]   = req_wdata;

        status                          = '0;
        status[CNT_LSB +: CNT_FIELD_W]  = CNT_FIELD_W'(q_cnt[qsel]);
        status[OVF_BIT]                 = q_ovf[qsel];

        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && dec.bad;
        rsp_d.data  = '0;
        if (acc_ok && !req_write)
            rsp_d.data = dec.is_state ? status : head_word[qsel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;
endmodule

// File: rtl/msg_mailbox_chk.sv
module msg_mailbox_chk
    import mbx_pkg::*;
#(
    parameter int NUM_QUEUE = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [3:0]           req_strb,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [DATA_W-1:0]    rsp_rdata,
    input logic [NUM_QUEUE-1:0] irq
);
    localparam int QW = $clog2(NUM_QUEUE);

    p_rsp_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    p_bad_strb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_strb != 4'hF) |=> rsp_err);

    p_misaligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);

    p_state_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[ADDR_W-1]) |=> rsp_err);

    p_err_keeps_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_strb != 4'hF) |=> $stable(irq));

    p_idle_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(irq));

    p_status_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && $past(req_addr[ADDR_W-1] && !req_write))
        |-> (rsp_rdata[31:24] == 8'h00 && rsp_rdata[11:1] == 11'h000));

    p_irq_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && $past(req_addr[ADDR_W-1] && !req_write))
        |-> ((rsp_rdata[23:12] != 12'h000) == irq[$past(req_addr[REG_LSB +: QW])]));
endmodule

bind msg_mailbox msg_mailbox_chk #(.NUM_QUEUE(NUM_QUEUE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_strb  (req_strb),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .irq       (irq)
);

// File: tb/msg_mailbox_tb.sv
`timescale 1ns/1ps
module msg_mailbox_tb;
    localparam int NP = 2, NQ = 8, DEPTH = 4, W = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_strb = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [NQ-1:0] irq;

    int checks = 0, errors = 0;
    logic [31:0] got;

    logic [31:0] mq  [NQ][DEPTH][W];
    int          mhead [NQ];
    int          mcnt  [NQ];
    bit          movf  [NQ];
    logic [31:0] mst [NP][NQ][W];

    always #2.5 clk = ~clk;

    msg_mailbox #(.NUM_PROXY(NP), .NUM_QUEUE(NQ), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] daddr(input int p, input int q, input int idx);
        return 20'(p * 'h10000 + q * 'h80 + idx * 4);
    endfunction

    function automatic logic [19:0] saddr(input int q);
        return 20'('h80000 + q * 4);
    endfunction

    // queue model built from the requirements
    task automatic model(input bit wr, input logic [19:0] a, input logic [3:0] s,
                         input logic [31:0] wd, output bit eerr, output logic [31:0] ed);
        int p, q, idx, w, slot;
        eerr = (s != 4'hF) || (a[1:0] != 2'b00);
        ed   = '0;
        if (a[19]) begin
            q    = int'(a[18:2]);
            eerr = eerr || wr || (q >= NQ);
            if (!eerr) begin
                ed[23:12] = 12'(mcnt[q]);
                ed[0]     = movf[q];
            end
        end else begin
            p    = int'(a[18:16]);
            q    = int'(a[15:7]);
            idx  = int'(a[6:2]);
            eerr = eerr || (p >= NP) || (q >= NQ) || (idx < 16);
            if (!eerr) begin
                w = idx - 16;
                if (wr) begin
                    if (w == W - 1) begin
                        if (mcnt[q] < DEPTH) begin
                            slot = (mhead[q] + mcnt[q]) % DEPTH;
                            for (int k = 0; k < W - 1; k++) mq[q][slot][k] = mst[p][q][k];
                            mq[q][slot][W-1] = wd;
                            mcnt[q]++;
                        end else begin
                            movf[q] = 1'b1;
                        end
                        for (int k = 0; k < W; k++) mst[p][q][k] = '0;
                    end else begin
                        mst[p][q][w] = wd;
                    end
                end else if (mcnt[q] > 0) begin
                    ed = mq[q][mhead[q]][w];
                    if (w == W - 1) begin
                        mhead[q] = (mhead[q] + 1) % DEPTH;
                        mcnt[q]--;
                    end
                end
            end
        end
    endtask

    task automatic op(input string req, input bit wr, input logic [19:0] a,
                      input logic [3:0] s, input logic [31:0] wd);
        bit          eerr;
        logic [31:0] ed;
        logic [NQ-1:0] eirq;
        model(wr, a, s, wd, eerr, ed);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_strb = s; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got = rsp_rdata;
        for (int k = 0; k < NQ; k++) eirq[k] = (mcnt[k] != 0);
        check({req, " (R9 rsp_valid)"}, 32'(rsp_valid), 32'd1);
        check({req, " (R8 err)"}, 32'(rsp_err), 32'(eerr));
        check({req, " data"}, rsp_rdata, ed);
        check({req, " (R7 irq)"}, 32'(irq), 32'(eirq));
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7531));
        for (int q = 0; q < NQ; q++) begin
            mhead[q] = 0; mcnt[q] = 0; movf[q] = 1'b0;
            for (int p = 0; p < NP; p++)
                for (int k = 0; k < W; k++) mst[p][q][k] = '0;
        end
        repeat (4) @(negedge clk);
        check("R12 irq after reset", 32'(irq), 32'd0);
        check("R12 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle gives no response", 32'(rsp_valid), 32'd0);
        op("R12 status q0", 0, saddr(0), 4'hF, 0);
        check("R12 status q0 empty", got, 32'h0);

        // R2: partial staging, zero fill, commit through proxy 0
        op("R2 stage w0", 1, daddr(0, 2, 16), 4'hF, 32'hA0);
        op("R2 stage w3", 1, daddr(0, 2, 19), 4'hF, 32'hA3);
        op("R2 commit", 1, daddr(0, 2, 31), 4'hF, 32'hAF);
        op("R2 second commit", 1, daddr(0, 2, 31), 4'hF, 32'hBF);
        // R1: read through the other proxy window of the same queue
        op("R1 read w0 via proxy1", 0, daddr(1, 2, 16), 4'hF, 0);
        check("R1 word0 via proxy1", got, 32'hA0);
        op("R2 read w1", 0, daddr(1, 2, 17), 4'hF, 0);
        check("R2 unwritten word zero", got, 32'h0);
        op("R4 peek w3", 0, daddr(0, 2, 19), 4'hF, 0);
        op("R4 peek w3 again", 0, daddr(0, 2, 19), 4'hF, 0);
        check("R4 peek has no side effect", got, 32'hA3);
        op("R4 pop", 0, daddr(0, 2, 31), 4'hF, 0);
        check("R4 pop returns last word", got, 32'hAF);
        op("R2 staging cleared", 0, daddr(0, 2, 16), 4'hF, 0);
        check("R2 staging cleared after commit", got, 32'h0);
        op("R4 pop second", 0, daddr(0, 2, 31), 4'hF, 0);

        // R10: staging isolation between proxies
        op("R10 stage proxy1", 1, daddr(1, 3, 16), 4'hF, 32'h11);
        op("R10 commit proxy0", 1, daddr(0, 3, 31), 4'hF, 32'h22);
        op("R10 commit proxy1", 1, daddr(1, 3, 31), 4'hF, 32'h33);
        op("R10 read first", 0, daddr(0, 3, 16), 4'hF, 0);
        check("R10 proxy0 message has no proxy1 word", got, 32'h0);
        op("R10 pop first", 0, daddr(0, 3, 31), 4'hF, 0);
        op("R10 read second", 0, daddr(0, 3, 16), 4'hF, 0);
        check("R10 proxy1 message word0", got, 32'h11);
        op("R10 pop second", 0, daddr(0, 3, 31), 4'hF, 0);

        // R3: overflow on the fifth commit
        for (int i = 0; i < 5; i++) op("R3 fill", 1, daddr(0, 5, 31), 4'hF, 32'h50 + i);
        op("R3 status", 0, saddr(5), 4'hF, 0);
        check("R3 status full with overflow", got, 32'h0000_4001);
        check("R7 irq5 high", 32'(irq[5]), 32'd1);
        // R11: order
        for (int i = 0; i < 4; i++) begin
            op("R11 pop", 0, daddr(1, 5, 31), 4'hF, 0);
            check("R11 commit order", got, 32'h50 + i);
        end
        // R5: empty reads
        op("R5 empty pop", 0, daddr(0, 5, 31), 4'hF, 0);
        check("R5 empty read zero", got, 32'h0);
        op("R5 status", 0, saddr(5), 4'hF, 0);
        check("R5 count zero, R3 flag sticky", got, 32'h0000_0001);
        check("R7 irq5 low", 32'(irq[5]), 32'd0);

        // R8: rejected accesses
        op("R8 bad strobe commit", 1, daddr(0, 6, 31), 4'h7, 32'h66);
        op("R8 low index", 1, daddr(0, 6, 4), 4'hF, 32'h66);
        op("R8 status write", 1, saddr(6), 4'hF, 32'h66);
        op("R8 proxy missing", 1, daddr(2, 6, 31), 4'hF, 32'h66);
        op("R8 misaligned", 1, daddr(0, 6, 31) + 20'd1, 4'hF, 32'h66);
        op("R8 stray bit", 0, daddr(0, 6, 16) | 20'h00400, 4'hF, 0);
        op("R8 state check", 0, saddr(6), 4'hF, 0);
        check("R8 queue6 untouched", got, 32'h0);
        op("R6 queue7 status", 0, saddr(7), 4'hF, 0);

        // seeded random traffic on queues 0..3
        for (int i = 0; i < 1500; i++) begin
            int k, p, q;
            logic [3:0] s;
            k = $urandom_range(0, 19);
            p = $urandom_range(0, NP - 1);
            q = $urandom_range(0, 3);
            s = ($urandom_range(0, 24) == 0) ? 4'h3 : 4'hF;
            if (k < 9)       op("R2 rnd stage", 1, daddr(p, q, $urandom_range(16, 30)), s, $urandom);
            else if (k < 13) op("R11 rnd commit", 1, daddr(p, q, 31), s, $urandom);
            else if (k < 16) op("R4 rnd pop", 0, daddr(p, q, 31), s, 0);
            else if (k < 18) op("R4 rnd peek", 0, daddr(p, q, $urandom_range(16, 30)), s, 0);
            else             op("R6 rnd status", 0, saddr(q), s, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule